// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the 32-bit status and control word that sits beside a floating-point datapath. Software uses it to set the rounding mode, the flush-denormals-to-zero control and one trap-enable bit for each IEEE exception. Hardware uses it to collect accumulated exception flags and per-operation cause bits.

On every cycle in which the datapath completes an operation, it presents the exceptions it detected and a marker for a denormal operand. The block then does the following:
- It adds the inexact exception that a masked overflow implies.
- It raises an unimplemented exception when a denormal operand meets a disabled flush control.
- It decides in the same cycle whether a trap must be requested.
- It overwrites the cause bits with this operation's exceptions.
- It merges the exceptions into the sticky flags, but only when no trap is requested.

Software reads the whole word at any time and writes it when no operation is reported. On a write the cause bits only accept zeros.

Top module: `fpu_status_reg`

Internal exception vector order, also used on `op_exc`: bit 0 invalid, bit 1 overflow, bit 2 divide-by-zero, bit 3 underflow, bit 4 inexact.

## Requirements
- R1: After reset the register reads 0x0000_0100: the flush control is 1 and every other bit is 0.
- R2: Register layout:
  - bit 31 is a read-only summary, equal to the OR of the underflow, divide-by-zero, overflow and invalid flags (inexact excluded);
  - flags sit at bits 30:26 (inexact, underflow, div-zero, overflow, invalid);
  - enables sit at bits 14:10 in the same order;
  - the flush control is bit 8;
  - causes sit at bits 7:2 (unimplemented, inexact, underflow, div-zero, overflow, invalid);
  - the rounding mode is bits 1:0;
  - all other bits read 0 and ignore writes.
- R3: A software write (`sw_we` with `op_valid` low) loads the flags, enables, flush control and rounding mode from `sw_wdata`. The rounding mode codes are 00 nearest, 01 toward zero, 10 toward +infinity and 11 toward -infinity, and they appear on `round_mode`.
- R4: On a software write, a cause bit written 0 is cleared and a cause bit written 1 keeps its value.
- R5: Every reported operation replaces all six cause bits with the exceptions of that operation, including implied ones.
- R6: `trap_req` is high, in the same cycle as `op_valid`, when any effective exception has its enable bit set or an unimplemented exception is raised.
- R7: When an operation requests no trap, its effective exceptions are ORed into the flags. Flags stay 1 across later operations until software writes them 0.
- R8: When an operation requests a trap, including when simultaneous exceptions have mixed enables, the flags do not change.
- R9: An overflow while the overflow enable is 0 also raises inexact, in both the cause bits and the flags. With the overflow enable at 1, no inexact is implied.
- R10: A denormal operand raises the unimplemented exception, which always traps, only while the flush control is 0. With the flush control at 1, it has no effect.
- R11: When `op_valid` and `sw_we` are high in the same cycle, the write is discarded and only the operation update takes place.
- R12: With `op_valid` low, `trap_req` is low, and `op_exc` and `op_denorm` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | The datapath reports a completed operation this cycle |
| op_exc | input | 5 | Exceptions detected by the operation (order above) |
| op_denorm | input | 1 | The operation saw a denormal operand |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Current register value |
| trap_req | output | 1 | Trap request for the reported operation |
| round_mode | output | 2 | Rounding mode for the datapath |
| flush_en | output | 1 | Flush-denormals-to-zero control |

## Verification
The bench builds the block with its default parameters: 32 data bits and five IEEE exceptions. These are the only values for which the fixed field positions line up, and they bring every field of the word within reach of the reference model. Directed sequences cover the following cases:
- a masked overflow implying inexact;
- mixed-enable simultaneous exceptions;
- the denormal path with the flush control set and cleared;
- cause write-zero-to-clear;
- a write colliding with an operation.

A random phase then mixes operations and writes, with the model compared against the register on every clock.

// File: rtl/fpu_stat_pkg.sv
package fpu_stat_pkg;
  // Field positions of the status word; a datapath decodes these.
  localparam int SUM_BIT   = 31;
  localparam int FLAG_LSB  = 26;
  localparam int EN_LSB    = 10;
  localparam int FLUSH_BIT = 8;
  localparam int CAUSE_LSB = 2;
  localparam int RM_LSB    = 0;

  // Index of each exception inside the internal vector.
  localparam int EXC_INV = 0;
  localparam int EXC_OVF = 1;
  localparam int EXC_DZ  = 2;
  localparam int EXC_UDF = 3;
  localparam int EXC_INX = 4;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_POS_INF = 2'b10,
    RND_NEG_INF = 2'b11
  } round_mode_e;
endpackage

// File: rtl/fpu_exc_qualify.sv
module fpu_exc_qualify
  import fpu_stat_pkg::*;
#(
  parameter int EXC_N = 5
) (
  input  logic             op_valid,
  input  logic [EXC_N-1:0] op_exc,
  input  logic             op_denorm,
  input  logic [EXC_N-1:0] trap_en,
  input  logic             flush_en,
  output logic [EXC_N-1:0] eff_exc,
  output logic             unimpl,
  output logic             trap
);
  logic [EXC_N-1:0] hit;

  // A masked overflow brings inexact along with it.
  always_comb begin
    eff_exc          = op_exc;
    eff_exc[EXC_INX] = op_exc[EXC_INX] | (op_exc[EXC_OVF] & ~trap_en[EXC_OVF]);
  end

  for (genvar i = 0; i < EXC_N; i++) begin : g_hit
    assign hit[i] = eff_exc[i] & trap_en[i];
  end

  assign unimpl = op_valid & op_denorm & ~flush_en;
  assign trap   = op_valid & ((|hit) | unimpl);
endmodule

// File: rtl/fpu_stat_next.sv
module fpu_stat_next #(
  parameter int EXC_N = 5,
  parameter int RM_W  = 2
) (
  input  logic             op_valid,
  input  logic [EXC_N-1:0] eff_exc,
  input  logic             unimpl,
  input  logic             trap,
  input  logic             sw_we,
  input  logic [EXC_N-1:0] wr_flags,
  input  logic [EXC_N-1:0] wr_en,
  input  logic             wr_flush,
  input  logic [EXC_N:0]   wr_cause,
  input  logic [RM_W-1:0]  wr_rm,
  input  logic [EXC_N-1:0] cur_flags,
  input  logic [EXC_N-1:0] cur_en,
  input  logic             cur_flush,
  input  logic [EXC_N:0]   cur_cause,
  input  logic [RM_W-1:0]  cur_rm,
  output logic [EXC_N-1:0] nxt_flags,
  output logic [EXC_N-1:0] nxt_en,
  output logic             nxt_flush,
  output logic [EXC_N:0]   nxt_cause,
  output logic [RM_W-1:0]  nxt_rm
);
  always_comb begin
    nxt_flags = cur_flags;
    nxt_en    = cur_en;
    nxt_flush = cur_flush;
    nxt_cause = cur_cause;
    nxt_rm    = cur_rm;
    if (op_valid) begin
      nxt_cause = {unimpl, eff_exc};
      if (!trap) nxt_flags = cur_flags | eff_exc;
    end else if (sw_we) begin
      nxt_flags = wr_flags;
      nxt_en    = wr_en;
      nxt_flush = wr_flush;
      nxt_cause = cur_cause & wr_cause;
      nxt_rm    = wr_rm;
    end
  end
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
  import fpu_stat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXC_N  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [EXC_N-1:0]  op_exc,
  input  logic              op_denorm,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              trap_req,
  output logic [1:0]        round_mode,
  output logic              flush_en
);
  localparam int RM_W    = 2;
  localparam int CAUSE_W = EXC_N + 1;

  logic [EXC_N-1:0]   flags_q, en_q, flags_d, en_d, eff_exc;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [RM_W-1:0]    rm_q, rm_d;
  logic               flush_q, flush_d, unimpl, trap, upd_en;
  logic               unused_wr;

  assign unused_wr = &{1'b0, sw_wdata[SUM_BIT], sw_wdata[FLAG_LSB-1:EN_LSB+EXC_N],
                       sw_wdata[FLUSH_BIT+1], sw_wdata[EN_LSB-1:FLUSH_BIT+1]};

  fpu_exc_qualify #(.EXC_N(EXC_N)) u_qual (
    .op_valid (op_valid),
    .op_exc   (op_exc),
    .op_denorm(op_denorm),
    .trap_en  (en_q),
    .flush_en (flush_q),
    .eff_exc  (eff_exc),
    .unimpl   (unimpl),
    .trap     (trap)
  );

  fpu_stat_next #(.EXC_N(EXC_N), .RM_W(RM_W)) u_next (
    .op_valid (op_valid),
    .eff_exc  (eff_exc),
    .unimpl   (unimpl),
    .trap     (trap),
    .sw_we    (sw_we),
    .wr_flags (sw_wdata[FLAG_LSB +: EXC_N]),
    .wr_en    (sw_wdata[EN_LSB +: EXC_N]),
    .wr_flush (sw_wdata[FLUSH_BIT]),
    .wr_cause (sw_wdata[CAUSE_LSB +: CAUSE_W]),
    .wr_rm    (sw_wdata[RM_LSB +: RM_W]),
    .cur_flags(flags_q),
    .cur_en   (en_q),
    .cur_flush(flush_q),
    .cur_cause(cause_q),
    .cur_rm   (rm_q),
    .nxt_flags(flags_d),
    .nxt_en   (en_d),
    .nxt_flush(flush_d),
    .nxt_cause(cause_d),
    .nxt_rm   (rm_d)
  );

  assign upd_en = op_valid | sw_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      flush_q <= 1'b1;
      cause_q <= '0;
      rm_q    <= RND_NEAREST;
    end else if (upd_en) begin
      flags_q <= flags_d;
      en_q    <= en_d;
      flush_q <= flush_d;
      cause_q <= cause_d;
      rm_q    <= rm_d;
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[SUM_BIT]              = flags_q[EXC_UDF] | flags_q[EXC_DZ] |
                                    flags_q[EXC_OVF] | flags_q[EXC_INV];
    rd_data[FLAG_LSB +: EXC_N]    = flags_q;
    rd_data[EN_LSB +: EXC_N]      = en_q;
    rd_data[FLUSH_BIT]            = flush_q;
    rd_data[CAUSE_LSB +: CAUSE_W] = cause_q;
    rd_data[RM_LSB +: RM_W]       = rm_q;
  end

  assign trap_req   = trap;
  assign round_mode = rm_q;
  assign flush_en   = flush_q;
endmodule

// File: rtl/fpu_status_reg_chk.sv
module fpu_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [4:0]  op_exc,
  input logic        op_denorm,
  input logic        trap_req,
  input logic [31:0] rd_data
);
  // R2
  summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == (|rd_data[29:26]));
  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[25:15] == '0 && rd_data[9] == 1'b0);
  // R12
  idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !trap_req);
  // R10
  denorm_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_denorm && !rd_data[8]) |-> trap_req);
  // R8
  trap_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && trap_req) |=> $stable(rd_data[30:26]));
  // R5
  cause_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((rd_data[6:2] & $past(op_exc)) == $past(op_exc)));
  // R11
  op_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ($stable(rd_data[14:10]) && $stable(rd_data[8]) && $stable(rd_data[1:0])));
endmodule

bind fpu_status_reg fpu_status_reg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_exc   (op_exc),
  .op_denorm(op_denorm),
  .trap_req (trap_req),
  .rd_data  (rd_data)
);

// File: tb/fpu_status_reg_bench.sv
module fpu_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_exc = '0;
  logic        op_denorm = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] rd_data;
  logic        trap_req;
  logic [1:0]  round_mode;
  logic        flush_en;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m;   // reference image of the register

  always #4 clk = ~clk;   // 125 MHz

  fpu_status_reg u_fpu_status_reg (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
    .op_denorm(op_denorm), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .rd_data(rd_data), .trap_req(trap_req), .round_mode(round_mode),
    .flush_en(flush_en)
  );

  // Effective exceptions: bit0 inv, bit1 ovf, bit2 dz, bit3 udf, bit4 inx
  function automatic logic [4:0] m_eff(input logic [4:0] e);
    logic [4:0] r = e;
    if (e[1] && !m[11]) r[4] = 1'b1;
    return r;
  endfunction

  function automatic logic m_trap(input logic v, input logic [4:0] e, input logic d);
    if (!v) return 1'b0;
    return (|(m_eff(e) & m[14:10])) || (d && !m[8]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [4:0] e, input logic d,
                      input logic we, input logic [31:0] wd, input string tag);
    logic t;
    logic [31:0] n;
    @(negedge clk);
    op_valid = v; op_exc = e; op_denorm = d; sw_we = we; sw_wdata = wd;
    #1;
    t = m_trap(v, e, d);
    check({tag, " trap"}, {31'b0, trap_req}, {31'b0, t});
    n = m;
    if (v) begin
      n[7:2] = {d && !m[8], m_eff(e)};
      if (!t) n[30:26] = m[30:26] | m_eff(e);
    end else if (we) begin
      n[30:26] = wd[30:26];
      n[14:10] = wd[14:10];
      n[8]     = wd[8];
      n[1:0]   = wd[1:0];
      n[7:2]   = m[7:2] & wd[7:2];
    end
    n[31] = n[29] | n[28] | n[27] | n[26];
    @(posedge clk);
    m = n;
    #1;
    check({tag, " reg"}, rd_data, m);
    check({tag, " ctl"}, {29'b0, flush_en, round_mode}, {29'b0, m[8], m[1:0]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m = 32'h0000_0100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset", rd_data, 32'h0000_0100);
    check("R1 reset trap", {31'b0, trap_req}, 32'h0);
    // R2 R3: write all ones; unused bits and summary stay derived
    step(0, 5'h00, 0, 1, 32'hFFFF_FFFF, "R2 R3 all ones");
    step(0, 5'h00, 0, 1, 32'h0000_0000, "R3 clear");
    for (int r = 0; r < 4; r++)
      step(0, 5'h00, 0, 1, 32'(r), "R3 rounding mode");
    // R2 R7: inexact alone does not raise summary
    step(1, 5'h10, 0, 0, 0, "R2 R7 inexact");
    step(1, 5'h08, 0, 0, 0, "R5 R7 underflow");
    step(1, 5'h00, 0, 0, 0, "R5 R7 quiet op");
    // R6 R9: enabled overflow traps, no implied inexact
    step(0, 5'h00, 0, 1, 32'h0000_0800, "R3 en ovf");
    step(1, 5'h02, 0, 0, 0, "R6 R9 ovf enabled");
    // R8: mixed enables
    step(1, 5'h06, 0, 0, 0, "R8 mixed");
    // R9: masked overflow implies inexact
    step(0, 5'h00, 0, 1, 32'h0, "R3 clear");
    step(1, 5'h02, 0, 0, 0, "R9 ovf masked");
    // R9 + inexact enabled: implied inexact traps
    step(0, 5'h00, 0, 1, 32'h0000_4000, "R3 en inx");
    step(1, 5'h02, 0, 0, 0, "R9 R6 implied inx trap");
    // R10: denormal with flush off, then on
    step(0, 5'h00, 0, 1, 32'h0, "R3 flush off");
    step(1, 5'h00, 1, 0, 0, "R10 unimpl");
    step(0, 5'h00, 0, 1, 32'h0000_0100, "R3 flush on");
    step(1, 5'h00, 1, 0, 0, "R10 flushed");
    // R4: cause write-zero-to-clear
    step(1, 5'h05, 0, 0, 0, "R5 inv dz");
    step(0, 5'h00, 0, 1, 32'h0000_0104, "R4 keep inv clear dz");
    step(0, 5'h00, 0, 1, 32'h0000_00FD, "R4 ones keep");
    // R11: collision
    step(1, 5'h01, 0, 1, 32'hFFFF_FFFF, "R11 collision");
    // R12: idle with noise on inputs
    step(0, 5'h1F, 1, 0, 32'hFFFF_FFFF, "R12 idle");
    step(0, 5'h1F, 0, 0, 0, "R12 idle");
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic v, w, d;
      logic [31:0] wd;
      v  = ($urandom % 3) == 0;
      w  = ($urandom % 4) == 0;
      d  = ($urandom % 5) == 0;
      wd = $urandom;
      step(v, 5'($urandom), d, w, wd, "R5 R6 R7 R8 random");
    end
    finish_run();
  end
endmodule